// File: doc/BRIEF.md
# Sense-Reversing Centralized Barrier

This block synchronises a fixed group of participants, for example engines or hardware threads that must all reach a common point before any of them continues. Each participant raises its `arrive` bit for one cycle when it reaches the barrier. It then waits until its `released` bit pulses, which tells it that every participant has arrived. Arrivals are tallied in a single shared counter. A single global release flag ends the episode. Each participant also holds its own private sense bit.

When a participant enters, it first inverts its private sense bit and then adds itself to the shared counter. Several participants may enter in the same cycle, and all of them are counted. The arrival that completes the group clears the counter and writes the new sense into the global flag. Each participant is released once the flag equals its own sense. The flag takes opposite values in successive episodes, so one episode is told apart from the next without a second counter, and the barrier can be reused at once. `arrive` and `released` are plain control pins. The block gives no handshake and applies no back-pressure: the release is a single-cycle pulse that the participant must catch, and an arrival the block does not accept is simply dropped.

Top module: `sr_barrier`

## Requirements
- R1: After reset, no `released` bit is high, no participant is waiting and the arrival count is zero.
- R2: No `released` bit goes high until NPART distinct participants have arrived in the current episode.
- R3: When the arrival that brings the count to NPART is sampled at a clock edge, every bit of `released` is high during the following cycle, and only for that one cycle.
- R4: Arrivals from several participants in the same cycle are all counted, each one adding one to the tally.
- R5: An `arrive` from a participant that is already waiting is ignored. This includes its release cycle, and it neither adds to the count nor brings the release forward.
- R6: A participant may arrive again in the cycle right after its release pulse, and that arrival counts toward the next episode.
- R7: The global release flag changes only when an episode completes, at which point the count returns to zero, and the stored count always stays below NPART.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| arrive | input | NPART | One bit per participant; high for a cycle to enter the barrier |
| released | output | NPART | One bit per participant; single-cycle pulse when the episode completes |

## Verification
The bench repeats an `arrive` from a participant that is already waiting. A design that counted the repeat would release the group one arrival early. The bench also asserts arrivals from every participant during the release cycle itself; a design that accepted them would start a phantom episode, and the next real release would come early or never. The bench completes an episode with a single cycle in which everyone arrives, and another with two partial groups. A design that counted one arrival per cycle would never reach the group size. Finally, it re-enters the barrier in the cycle right after each release. A design without a correctly alternating flag would hang there, or would release again on stale sense.

// File: rtl/sr_barrier_pkg.sv
package sr_barrier_pkg;
  localparam int unsigned SRB_DEF_PARTS = 5;

  // width of a counter that must hold values 0..n
  function automatic int unsigned srb_cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/sr_barrier_slot.sv
module sr_barrier_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic arrive,
  input  logic gflag,
  output logic accept,
  output logic sense_next,
  output logic waiting,
  output logic released
);
  logic sense_q;
  logic wait_q;

  // an arrival counts only while the slot is idle
  assign accept     = arrive & ~wait_q;
  assign sense_next = ~sense_q;
  assign waiting    = wait_q;
  assign released   = wait_q & (gflag == sense_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q <= 1'b0;
      wait_q  <= 1'b0;
    end else if (released) begin
      wait_q <= 1'b0;
    end else if (accept) begin
      sense_q <= ~sense_q;   // flip private sense first
      wait_q  <= 1'b1;
    end
  end
endmodule

// File: rtl/sr_barrier_tally.sv
module sr_barrier_tally #(
  parameter int unsigned NPART = 5,
  parameter int unsigned CW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPART-1:0] accept,
  input  logic [NPART-1:0] sense_next,
  output logic [CW-1:0]    count,
  output logic             gflag
);
  logic [CW:0]   sum;
  logic          done;
  logic [CW-1:0] count_q;
  logic          flag_q;

  // add the number of accepted arrivals in this cycle
  always_comb begin
    sum = {1'b0, count_q};
    for (int i = 0; i < int'(NPART); i++) begin
      sum = sum + (CW+1)'(accept[i]);
    end
    done = (sum == (CW+1)'(NPART));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      flag_q  <= 1'b0;
    end else if (done) begin
      count_q <= '0;
      flag_q  <= |(accept & sense_next);  // completing arrivals' new sense
    end else begin
      count_q <= sum[CW-1:0];
    end
  end

  assign count = count_q;
  assign gflag = flag_q;
endmodule

// File: rtl/sr_barrier.sv
module sr_barrier
  import sr_barrier_pkg::*;
#(
  parameter int unsigned NPART = SRB_DEF_PARTS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPART-1:0] arrive,
  output logic [NPART-1:0] released
);
  localparam int unsigned CW = srb_cnt_width(NPART);

  logic [NPART-1:0] acc_vec;
  logic [NPART-1:0] nsense_vec;
  logic [NPART-1:0] wait_vec;
  logic [CW-1:0]    cnt_q;
  logic             flag_q;

  for (genvar g = 0; g < int'(NPART); g++) begin : g_slot
    sr_barrier_slot u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .arrive     (arrive[g]),
      .gflag      (flag_q),
      .accept     (acc_vec[g]),
      .sense_next (nsense_vec[g]),
      .waiting    (wait_vec[g]),
      .released   (released[g])
    );
  end

  sr_barrier_tally #(.NPART(NPART), .CW(CW)) u_tally (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (acc_vec),
    .sense_next (nsense_vec),
    .count      (cnt_q),
    .gflag      (flag_q)
  );
endmodule

// File: rtl/sr_barrier_chk.sv
module sr_barrier_chk #(
  parameter int unsigned NPART = 5,
  parameter int unsigned CW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPART-1:0] arrive,
  input logic [NPART-1:0] released,
  input logic [NPART-1:0] waiting_q,
  input logic [CW-1:0]    count_q,
  input logic             flag_q
);
  // R3: the whole group is released together
  p_all_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|released) |-> (&released));

  // R3: release lasts a single cycle
  p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|released) |=> !(|released));

  // R4: count grows by the number of newly accepted arrivals
  p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q != '0) |->
      (int'(count_q) == int'($past(count_q)) + $countones($past(arrive & ~waiting_q))));

  // R5: a waiting participant stays waiting until released
  p_wait_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(waiting_q & ~released)) |=>
      ((waiting_q & $past(waiting_q & ~released)) == $past(waiting_q & ~released)));

  // R7: flag moves only on completion, with the count back at zero
  p_flag_on_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q != $past(flag_q)) |-> ((count_q == '0) && (&waiting_q)));

  // R7: stored count never reaches the group size
  p_count_below_r7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count_q) < int'(NPART));
endmodule

bind sr_barrier sr_barrier_chk #(.NPART(NPART), .CW(CW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .arrive    (arrive),
  .released  (released),
  .waiting_q (wait_vec),
  .count_q   (cnt_q),
  .flag_q    (flag_q)
);

// File: tb/sr_barrier_tb_top.sv
module sr_barrier_tb_top;
  localparam int NP = 5;
  localparam logic [NP-1:0] ALL = '1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] arrive = '0;
  logic [NP-1:0] released;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    logic [NP-1:0] exp;
    string         tag;
  } item_t;
  item_t sb_q[$];

  // bench model state
  logic [NP-1:0] m_wait = '0;
  int            m_cnt = 0;
  bit            m_rel = 0;

  always #10 clk = ~clk;  // 50 MHz

  sr_barrier #(.NPART(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .arrive(arrive), .released(released)
  );

  // monitor: compare previous cycle's prediction
  always @(negedge clk) begin
    if (rst_n && sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_run++;
      if (released !== it.exp) begin
        n_fail++;
        $display("FAIL %s: released=%b expected=%b", it.tag, released, it.exp);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: cycles=%0d expected<=5000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  // driver: apply one arrive vector, predict next-cycle release
  task automatic drive(input logic [NP-1:0] a, input string tag);
    logic [NP-1:0] acc;
    @(negedge clk);
    #1;
    arrive = a;
    if (m_rel) begin
      m_wait = '0;
      m_cnt  = 0;
      m_rel  = 0;
    end else begin
      acc    = a & ~m_wait;
      m_wait = m_wait | acc;
      m_cnt  = m_cnt + $countones(acc);
      if (m_cnt == NP) begin
        m_cnt = 0;
        m_rel = 1;
      end
    end
    sb_q.push_back('{exp: (m_rel ? ALL : '0), tag: tag});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    n_run++;
    if (released !== '0) begin
      n_fail++;
      $display("FAIL R1: released=%b expected=%b", released, {NP{1'b0}});
    end
    rst_n = 1'b1;
    drive('0, "R1");

    // sequential arrivals, no early release
    drive(5'b00001, "R2");
    drive(5'b00010, "R2");
    drive(5'b00100, "R2");
    drive(5'b01000, "R2");
    // repeat from waiting participant ignored
    drive(5'b00001, "R5");
    drive(5'b00011, "R5");
    // last arrival
    drive(5'b10000, "R3");
    // all arrive during release cycle: ignored
    drive(ALL, "R5");
    drive('0, "R3");
    // one-cycle full arrival
    drive(ALL, "R4");
    drive('0, "R3");
    // re-arrive right after release
    drive(ALL, "R6");
    drive(ALL, "R5");
    drive(ALL, "R6");
    drive('0, "R6");
    // two partial groups
    drive(5'b00011, "R4");
    drive(5'b00011, "R5");
    drive(5'b11100, "R4");
    drive(5'b00100, "R6");
    drive(5'b11011, "R6");
    drive('0, "R7");
    drive(5'b10101, "R7");
    drive(5'b01010, "R7");
    drive('0, "R7");
    drive('0, "R7");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule